// File: doc/BRIEF.md
# Service Request and Serial Poll Unit

This block gives an instrument its service-request behaviour on a byte-serial instrumentation bus. Firmware holds an eight-bit status byte and an eight-bit condition mask in the block. When any status bit whose mask bit is also set is true, the block pulls the active-low service request line. Firmware can also request service directly in one of two ways. The first way sets the request bit inside the status byte and must clear it again later. The second way is a request command that withdraws itself as soon as the controller has taken the poll byte. Because the second way withdraws itself, an old request cannot reappear when another device on the bus asks for service.

Device hardware can raise status bits through single-cycle condition pulses. The controller-command decoder reports when a serial poll is active and when the device is addressed to talk. During that window, the block presents the status byte with the request bit replaced by the live request state. When the controller accepts the byte, the block emits a one-cycle poll-complete pulse. A change of request state that happens while a poll byte is on offer is held back until the byte is accepted or the talk window closes.

Top module: `svc_req_poll`

## Requirements
- R1: After reset, `srq_n` is 1, `poll_valid` is 0, `poll_done` is 0, and the status byte, the mask and the command request are all zero.
- R2: A host write with `host_sel`=0 loads the status byte, and `host_sel`=1 loads the mask. If a status bit other than bit 6 (value 0x40) is 1 and its mask bit is also 1, `srq_n` goes low after the clock edge that takes the write. `srq_n` returns high after the edge that clears either the status bit or the mask bit.
- R3: A status bit whose mask bit is 0 never lowers `srq_n`. Mask bit 6 has no effect.
- R4: Bit-request mode: writing status bit 6 (0x40) as 1 lowers `srq_n`. The request stays up through an accepted poll and ends only when the host writes bit 6 as 0.
- R5: Command-request mode: a write with `host_sel`=2 and data 0x98 raises the command request, and data 0x18 withdraws it. An accepted poll byte also withdraws it. If 0x98 arrives in the same cycle as an acceptance, the request is set.
- R6: Each 1 bit of `cond_set` sets the matching status bit on the clock edge. A status write in the same cycle is applied first, and the pulse bits are then added on top of it. Bit 6 of `cond_set` is ignored.
- R7: `poll_valid` is `spoll_act` AND `talk_addr`. `poll_byte` is the status byte with bit 6 replaced by the current request state (1 when `srq_n` is 0).
- R8: `byte_acc` during `poll_valid` is an acceptance: `poll_done` is 1 for exactly the cycle after it. A `byte_acc` outside `poll_valid` is ignored: it gives no pulse and does not withdraw the command request.
- R9: While `poll_valid` is 1 and no acceptance occurs, `srq_n` and the request bit in `poll_byte` stay frozen. Any pending change shows up after the accepting edge, or after the edge where `poll_valid` falls.
- R10: A write with `host_sel`=2 and any data other than 0x98 or 0x18 has no effect. A write with `host_sel`=3 also has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 2 | Register select: 0 status, 1 mask, 2 command, 3 unused |
| host_wdata | input | 8 | Host write data |
| cond_set | input | 8 | Per-bit condition pulses into the status byte |
| spoll_act | input | 1 | Serial poll active, from the command decoder |
| talk_addr | input | 1 | Device addressed to talk |
| byte_acc | input | 1 | Controller accepted the byte on the bus |
| srq_n | output | 1 | Service request, active low |
| poll_valid | output | 1 | Poll byte on offer |
| poll_byte | output | 8 | Status byte with the live request bit |
| poll_done | output | 1 | One-cycle pulse after a poll byte is accepted |

## Verification
Every registered result is due one clock edge after the stimulus that causes it. A host write, a condition pulse or an acceptance seen at edge k shows on `srq_n`, on the request bit of `poll_byte` and on `poll_done` just after edge k. `poll_valid` and the non-request bits of `poll_byte` follow the poll inputs and the stored status without extra delay. The driver changes inputs only at falling edges. After each rising edge it queues the values the requirements predict for that edge. The monitor compares them one time unit after the same rising edge, so each comparison lands exactly on the cycle where the result is due. The hold window is checked by changing the request during an open poll and expecting no change until the accepting edge.

// File: rtl/svc_pkg.sv
package svc_pkg;
    parameter int SB_W    = 8;
    parameter int RQS_POS = 6;
    parameter int SEL_W   = 2;

    localparam logic [SEL_W-1:0] SEL_STATUS = SEL_W'(0);
    localparam logic [SEL_W-1:0] SEL_MASK   = SEL_W'(1);
    localparam logic [SEL_W-1:0] SEL_CMD    = SEL_W'(2);

    localparam logic [SB_W-1:0] CMD_RSV_SET = SB_W'(8'h98);
    localparam logic [SB_W-1:0] CMD_RSV_CLR = SB_W'(8'h18);

    localparam logic [SB_W-1:0] RQS_ONLY = SB_W'(1) << RQS_POS;
    localparam logic [SB_W-1:0] NON_RQS  = ~RQS_ONLY;

    typedef struct packed {
        logic [SB_W-1:0] status;
        logic [SB_W-1:0] mask;
        logic            rsv;
    } regs_t;

    typedef struct packed {
        logic srq;
    } hold_t;

    typedef struct packed {
        logic done;
    } poll_t;
endpackage

// File: rtl/svc_host_regs.sv
module svc_host_regs
    import svc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic [SEL_W-1:0] host_sel,
    input  logic [SB_W-1:0]  host_wdata,
    input  logic [SB_W-1:0]  cond_set,
    input  logic             accept,
    output logic [SB_W-1:0]  status_q,
    output logic             req_nxt
);
    regs_t r_d, r_q;
    logic [SB_W-1:0] hit;
    logic wr_status, wr_mask, wr_cmd, cmd_set, cmd_clr;

    always_comb begin
        wr_status = host_wr && (host_sel == SEL_STATUS);
        wr_mask   = host_wr && (host_sel == SEL_MASK);
        wr_cmd    = host_wr && (host_sel == SEL_CMD);
        cmd_set   = wr_cmd && (host_wdata == CMD_RSV_SET);
        cmd_clr   = wr_cmd && (host_wdata == CMD_RSV_CLR);
    end

    always_comb begin
        r_d = r_q;
        if (wr_status) r_d.status = host_wdata;
        if (wr_mask)   r_d.mask   = host_wdata;
        r_d.status = r_d.status | (cond_set & NON_RQS);
        if (accept || cmd_clr) r_d.rsv = 1'b0;
        if (cmd_set)           r_d.rsv = 1'b1;
    end

    genvar gi;
    generate
        for (gi = 0; gi < SB_W; gi++) begin : g_hit
            if (gi == RQS_POS) begin : g_rqs
                assign hit[gi] = 1'b0;
            end else begin : g_dev
                assign hit[gi] = r_d.status[gi] & r_d.mask[gi];
            end
        end
    endgenerate

    assign req_nxt  = r_d.status[RQS_POS] | (|hit) | r_d.rsv;
    assign status_q = r_q.status;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R5
    rsv_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cmd_set) |=> !r_q.rsv);

    // R6
    cond_sets_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(cond_set & NON_RQS)) |=>
        ((status_q & $past(cond_set) & NON_RQS) == ($past(cond_set) & NON_RQS)));
endmodule

// File: rtl/svc_req_hold.sv
module svc_req_hold
    import svc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xfer,
    input  logic accept,
    input  logic req_nxt,
    output logic srq_q
);
    hold_t h_d, h_q;
    logic hold;

    always_comb begin
        hold = xfer && !accept;
        h_d  = h_q;
        if (!hold) h_d.srq = req_nxt;
    end

    assign srq_q = h_q.srq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    // R9
    srq_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !accept) |=> $stable(srq_q));

    // R2
    srq_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(xfer && !accept) && req_nxt) |=> srq_q);
endmodule

// File: rtl/svc_poll_out.sv
module svc_poll_out
    import svc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            spoll_act,
    input  logic            talk_addr,
    input  logic            byte_acc,
    input  logic [SB_W-1:0] status_q,
    input  logic            srq_q,
    output logic            xfer,
    output logic            accept,
    output logic            poll_valid,
    output logic [SB_W-1:0] poll_byte,
    output logic            poll_done
);
    poll_t p_d, p_q;

    always_comb begin
        xfer     = spoll_act && talk_addr;
        accept   = xfer && byte_acc;
        p_d.done = accept;
    end

    assign poll_valid = xfer;
    assign poll_byte  = (status_q & NON_RQS) | (srq_q ? RQS_ONLY : '0);
    assign poll_done  = p_q.done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    // R8
    done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_done |-> $past(poll_valid && byte_acc));
endmodule

// File: rtl/svc_req_poll.sv
module svc_req_poll
    import svc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [1:0]  host_sel,
    input  logic [7:0]  host_wdata,
    input  logic [7:0]  cond_set,
    input  logic        spoll_act,
    input  logic        talk_addr,
    input  logic        byte_acc,
    output logic        srq_n,
    output logic        poll_valid,
    output logic [7:0]  poll_byte,
    output logic        poll_done
);
    logic [SB_W-1:0] status_q;
    logic req_nxt, srq_q, xfer, accept;

    svc_host_regs u_regs (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .cond_set(cond_set), .accept(accept),
        .status_q(status_q), .req_nxt(req_nxt)
    );

    svc_req_hold u_hold (
        .clk(clk), .rst_n(rst_n), .xfer(xfer), .accept(accept),
        .req_nxt(req_nxt), .srq_q(srq_q)
    );

    svc_poll_out u_poll (
        .clk(clk), .rst_n(rst_n), .spoll_act(spoll_act), .talk_addr(talk_addr),
        .byte_acc(byte_acc), .status_q(status_q), .srq_q(srq_q),
        .xfer(xfer), .accept(accept), .poll_valid(poll_valid),
        .poll_byte(poll_byte), .poll_done(poll_done)
    );

    assign srq_n = ~srq_q;

    // R7
    rqs_matches_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_valid |-> (poll_byte[RQS_POS] == !srq_n));
endmodule

// File: tb/svc_req_poll_test.sv
`timescale 1ns/100ps
module svc_req_poll_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_wr = 1'b0;
    logic [1:0] host_sel = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] cond_set = '0;
    logic spoll_act = 1'b0, talk_addr = 1'b0, byte_acc = 1'b0;
    logic srq_n, poll_valid, poll_done;
    logic [7:0] poll_byte;

    always #2.5 clk = ~clk;

    svc_req_poll uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .cond_set(cond_set), .spoll_act(spoll_act),
        .talk_addr(talk_addr), .byte_acc(byte_acc), .srq_n(srq_n),
        .poll_valid(poll_valid), .poll_byte(poll_byte), .poll_done(poll_done)
    );

    typedef struct {
        logic       srq_n;
        logic       valid;
        logic [7:0] pbyte;
        logic       done;
        string      tag;
    } exp_t;

    exp_t sb[$];
    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [7:0] m_status = '0, m_mask = '0;
    logic       m_rsv = 0, m_srq = 0;

    task automatic step(input logic wen, input logic [1:0] sel, input logic [7:0] data,
                        input logic [7:0] cond, input logic sp, input logic tk,
                        input logic acc, input string tag);
        exp_t e;
        logic xfer, accept, req;
        @(negedge clk);
        host_wr = wen; host_sel = sel; host_wdata = data; cond_set = cond;
        spoll_act = sp; talk_addr = tk; byte_acc = acc;
        @(posedge clk);
        xfer = sp && tk;
        accept = xfer && acc;
        if (wen && sel == 2'd0) m_status = data;
        if (wen && sel == 2'd1) m_mask = data;
        m_status = m_status | (cond & 8'hBF);
        if (accept) m_rsv = 0;
        if (wen && sel == 2'd2 && data == 8'h18) m_rsv = 0;
        if (wen && sel == 2'd2 && data == 8'h98) m_rsv = 1;
        req = m_status[6] | (|(m_status & m_mask & 8'hBF)) | m_rsv;
        if (!(xfer && !accept)) m_srq = req;
        e.srq_n = !m_srq;
        e.valid = xfer;
        e.pbyte = (m_status & 8'hBF) | (m_srq ? 8'h40 : 8'h00);
        e.done  = accept;
        e.tag   = tag;
        sb.push_back(e);
    endtask

    // monitor: compares one time unit after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_vec++;
                if (srq_n !== e.srq_n || poll_valid !== e.valid ||
                    poll_byte !== e.pbyte || poll_done !== e.done) begin
                    n_bad++;
                    $display("FAIL %s: got srq_n=%b valid=%b byte=%h done=%b, expected srq_n=%b valid=%b byte=%h done=%b",
                             e.tag, srq_n, poll_valid, poll_byte, poll_done,
                             e.srq_n, e.valid, e.pbyte, e.done);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: reset state checked while reset is held
        #1;
        n_vec++;
        if (srq_n !== 1'b1 || poll_valid !== 1'b0 || poll_done !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: got srq_n=%b valid=%b done=%b, expected 1 0 0",
                     srq_n, poll_valid, poll_done);
        end
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 8'h00, 8'h00, 0, 0, 0, "R1 idle");
        step(0, 0, 8'h00, 8'h00, 0, 0, 0, "R1 idle");
        // R2 masked request
        step(1, 1, 8'h21, 8'h00, 0, 0, 0, "R2 mask write");
        step(1, 0, 8'h20, 8'h00, 0, 0, 0, "R2 masked status raises srq");
        step(1, 0, 8'h00, 8'h00, 0, 0, 0, "R2 status clear drops srq");
        step(1, 0, 8'h01, 8'h00, 0, 0, 0, "R2 second bit");
        step(1, 1, 8'h00, 8'h00, 0, 0, 0, "R2 mask clear drops srq");
        // R3 unmasked bits and mask bit 6
        step(1, 1, 8'h40, 8'h00, 0, 0, 0, "R3 mask bit6 only");
        step(1, 0, 8'h81, 8'h00, 0, 0, 0, "R3 unmasked status no srq");
        step(1, 0, 8'h00, 8'h00, 0, 0, 0, "R3 clear");
        // R4 bit-request mode
        step(1, 0, 8'h40, 8'h00, 0, 0, 0, "R4 status bit6 raises srq");
        step(0, 0, 8'h00, 8'h00, 1, 1, 0, "R7 poll byte shows rqs");
        step(0, 0, 8'h00, 8'h00, 1, 1, 1, "R4 accept keeps request");
        step(0, 0, 8'h00, 8'h00, 0, 0, 0, "R8 done pulse ends");
        step(1, 0, 8'h00, 8'h00, 0, 0, 0, "R4 host clears bit6");
        // R5 command-request mode
        step(1, 2, 8'h98, 8'h00, 0, 0, 0, "R5 command sets request");
        step(1, 2, 8'h18, 8'h00, 0, 0, 0, "R5 command clears request");
        step(1, 2, 8'h98, 8'h00, 0, 0, 0, "R5 command sets again");
        step(1, 0, 8'h20, 8'h00, 1, 1, 0, "R7 poll byte with status");
        step(0, 0, 8'h00, 8'h00, 1, 1, 1, "R5 accept self-clears");
        step(0, 0, 8'h00, 8'h00, 0, 0, 0, "R8 pulse single cycle");
        step(1, 2, 8'h98, 8'h00, 1, 1, 1, "R5 set wins over accept");
        // R8 strobe outside the poll window
        step(0, 0, 8'h00, 8'h00, 0, 1, 1, "R8 acc without poll ignored");
        step(0, 0, 8'h00, 8'h00, 1, 0, 1, "R8 acc without talk ignored");
        step(1, 2, 8'h18, 8'h00, 0, 0, 0, "R5 clear");
        // R6 condition pulses
        step(1, 0, 8'h00, 8'h00, 0, 0, 0, "R6 status clear");
        step(1, 1, 8'h01, 8'h00, 0, 0, 0, "R6 mask bit0");
        step(0, 0, 8'h00, 8'h01, 0, 0, 0, "R6 cond raises srq");
        step(1, 0, 8'h00, 8'h20, 0, 0, 0, "R6 write then cond merge");
        step(1, 1, 8'h00, 8'h40, 0, 0, 0, "R6 cond bit6 ignored");
        step(1, 1, 8'h01, 8'h00, 0, 0, 0, "R6 mask bit0 again");
        step(1, 0, 8'h00, 8'h01, 0, 0, 0, "R6 cond wins over write");
        // R9 hold during transfer
        step(1, 0, 8'h00, 8'h00, 0, 0, 0, "R9 clear status");
        step(1, 1, 8'h02, 8'h00, 1, 1, 0, "R9 open poll");
        step(1, 0, 8'h02, 8'h00, 1, 1, 0, "R9 new request held");
        step(0, 0, 8'h00, 8'h00, 1, 1, 0, "R9 still held");
        step(0, 0, 8'h00, 8'h00, 1, 1, 1, "R9 released at accept");
        step(1, 0, 8'h00, 8'h00, 1, 1, 0, "R9 drop held during poll");
        step(0, 0, 8'h00, 8'h00, 0, 0, 0, "R9 released at poll end");
        // R10 ignored writes
        step(1, 1, 8'hFF, 8'h00, 0, 0, 0, "R10 mask all");
        step(1, 2, 8'h55, 8'h00, 0, 0, 0, "R10 unknown command");
        step(1, 3, 8'h98, 8'h00, 0, 0, 0, "R10 select 3 ignored");
        step(1, 2, 8'h99, 8'h00, 0, 0, 0, "R10 near command ignored");
        step(0, 0, 8'h00, 8'h00, 1, 1, 0, "R10 poll byte unchanged");
        step(0, 0, 8'h00, 8'h00, 0, 0, 0, "R10 idle");
        @(posedge clk);
        @(posedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule